// File: doc/BRIEF.md
# Hiccup-Mode Overload Guard

This block decides, for one supply channel, whether the output regulator may drive its load while a short circuit or overload is present. It takes an overload indication that has already been synchronized to the clock, a mode bit, a one-millisecond tick, a standby enable and an undervoltage indication. It produces a regulator enable and an overload flag that software can read.

The mode bit selects one of two behaviours. In clamp mode the regulator stays on, the analog limiter holds the current, and the flag simply mirrors the overload. In hiccup mode an overload turns the output off for a long rest window. The output then comes back for a short trial window of one tenth that length. The fault is released only when a whole trial window passes with no overload seen, so a short into a large load costs little average power. Both window lengths are counted in ticks and set by parameters, which keeps simulation short.

Both outputs come from registers. Each reflects the inputs sampled at the previous rising clock edge.

Top module: `olp_pulsed_guard`

## Requirements
- R1: In hiccup mode (static_i=0), with the channel active (en_i=1, uvlo_i=0) and no fault in progress, an overload sampled at a clock edge drives out_en_o to 0 and ovl_flag_o to 1 from that edge.
- R2: The rest window lasts exactly OFF_TICKS tick pulses counted after the entry edge. Without tick pulses the output stays off. out_en_o returns to 1 at the edge that samples the last tick pulse, and ovl_flag_o stays 1.
- R3: The trial window lasts exactly ON_TICKS = OFF_TICKS/ON_DIV tick pulses (at least 1), and ovl_flag_o stays 1 throughout it.
- R4: An overload sampled in any cycle of the trial window, including the edge that ends it, starts a new rest window at the end of the trial.
- R5: When a trial window ends with no overload seen, the block returns to normal. out_en_o stays 1 and ovl_flag_o goes to 0 at the edge that ends the window.
- R6: In clamp mode (static_i=1) with the channel active, out_en_o is 1 and ovl_flag_o equals ovld_i as sampled at the previous edge.
- R7: Setting static_i to 1 in the middle of a rest or trial window ends the fault sequence at the next edge and applies the clamp-mode behaviour at once.
- R8: en_i=0 or uvlo_i=1 forces out_en_o=0 and ovl_flag_o=0 at the next edge and discards any fault in progress. A later re-enable with no overload gives out_en_o=1 and ovl_flag_o=0.
- R9: While rst_n is low, out_en_o and ovl_flag_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable; 0 is standby |
| uvlo_i | input | 1 | Supply undervoltage, active high |
| static_i | input | 1 | Protection mode: 1 clamp, 0 hiccup |
| ovld_i | input | 1 | Synchronized overload detect, active high |
| tick_i | input | 1 | One-cycle pulse per millisecond |
| out_en_o | output | 1 | Regulator output enable |
| ovl_flag_o | output | 1 | Overload diagnostic flag |

## Verification
A wrong internal state shows up at the ports. A state register stuck in the rest window keeps out_en_o low after the tick count that should end it. A lost dirty bit releases the fault at the end of a trial that contained an overload: ovl_flag_o drops to 0 where it should stay 1. An off-by-one in the window counter moves the out_en_o edge by one tick, and that shows within the first full rest window. A wrong mode priority makes out_en_o or ovl_flag_o differ from the clamp-mode or standby rule at the first edge after the mode or enable change.

// File: rtl/olp_pkg.sv
package olp_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_REST = 2'd1,
        ST_TRY  = 2'd2
    } olp_state_e;

    typedef struct packed {
        olp_state_e state;
        logic       dirty;
        logic       out_en;
        logic       flag;
    } olp_ctrl_s;

endpackage

// File: rtl/olp_window_timer.sv
module olp_window_timer #(
    parameter int unsigned OFF_TICKS = 900,
    parameter int unsigned ON_TICKS  = 90
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic tick_i,
    input  logic sel_on_i,
    output logic expire_o
);
    localparam int unsigned CNT_W = $clog2(OFF_TICKS + 1);
    localparam logic [CNT_W-1:0] OFF_LAST = CNT_W'(OFF_TICKS - 1);
    localparam logic [CNT_W-1:0] ON_LAST  = CNT_W'(ON_TICKS - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        last     = sel_on_i ? ON_LAST : OFF_LAST;
        expire_o = tick_i && (cnt_q == last);
        cnt_d    = cnt_q;
        if (clr_i || expire_o) begin
            cnt_d = '0;
        end else if (tick_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/olp_hiccup_ctrl.sv
module olp_hiccup_ctrl
    import olp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    input  logic static_i,
    input  logic ovld_i,
    input  logic expire_i,
    output logic clr_o,
    output logic sel_on_o,
    output logic out_en_o,
    output logic flag_o
);
    olp_ctrl_s c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (!act_i) begin
            c_d.state  = ST_RUN;
            c_d.dirty  = 1'b0;
            c_d.out_en = 1'b0;
            c_d.flag   = 1'b0;
        end else if (static_i) begin
            c_d.state  = ST_RUN;
            c_d.dirty  = 1'b0;
            c_d.out_en = 1'b1;
            c_d.flag   = ovld_i;
        end else begin
            unique case (c_q.state)
                ST_RUN: begin
                    c_d.dirty = 1'b0;
                    if (ovld_i) begin
                        c_d.state  = ST_REST;
                        c_d.out_en = 1'b0;
                        c_d.flag   = 1'b1;
                    end else begin
                        c_d.out_en = 1'b1;
                        c_d.flag   = 1'b0;
                    end
                end
                ST_REST: begin
                    c_d.out_en = 1'b0;
                    c_d.flag   = 1'b1;
                    if (expire_i) begin
                        c_d.state  = ST_TRY;
                        c_d.out_en = 1'b1;
                        c_d.dirty  = 1'b0;
                    end
                end
                ST_TRY: begin
                    c_d.out_en = 1'b1;
                    c_d.flag   = 1'b1;
                    c_d.dirty  = c_q.dirty | ovld_i;
                    if (expire_i) begin
                        c_d.dirty = 1'b0;
                        if (c_q.dirty || ovld_i) begin
                            c_d.state  = ST_REST;
                            c_d.out_en = 1'b0;
                        end else begin
                            c_d.state = ST_RUN;
                            c_d.flag  = 1'b0;
                        end
                    end
                end
                default: begin
                    c_d.state  = ST_RUN;
                    c_d.dirty  = 1'b0;
                    c_d.out_en = 1'b0;
                    c_d.flag   = 1'b0;
                end
            endcase
        end
    end

    assign clr_o    = (c_d.state != c_q.state) || (c_q.state == ST_RUN);
    assign sel_on_o = (c_q.state == ST_TRY);
    assign out_en_o = c_q.out_en;
    assign flag_o   = c_q.flag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.state  <= ST_RUN;
            c_q.dirty  <= 1'b0;
            c_q.out_en <= 1'b0;
            c_q.flag   <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

endmodule

// File: rtl/olp_pulsed_guard.sv
module olp_pulsed_guard #(
    parameter int unsigned OFF_TICKS = 900,
    parameter int unsigned ON_DIV    = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic uvlo_i,
    input  logic static_i,
    input  logic ovld_i,
    input  logic tick_i,
    output logic out_en_o,
    output logic ovl_flag_o
);
    localparam int unsigned ON_RAW   = OFF_TICKS / ON_DIV;
    localparam int unsigned ON_TICKS = (ON_RAW < 1) ? 1 : ON_RAW;

    logic act;
    logic clr;
    logic sel_on;
    logic expire;

    assign act = en_i && !uvlo_i;

    olp_window_timer #(
        .OFF_TICKS (OFF_TICKS),
        .ON_TICKS  (ON_TICKS)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr),
        .tick_i   (tick_i),
        .sel_on_i (sel_on),
        .expire_o (expire)
    );

    olp_hiccup_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_i    (act),
        .static_i (static_i),
        .ovld_i   (ovld_i),
        .expire_i (expire),
        .clr_o    (clr),
        .sel_on_o (sel_on),
        .out_en_o (out_en_o),
        .flag_o   (ovl_flag_o)
    );

endmodule

// File: rtl/olp_pulsed_guard_chk.sv
module olp_pulsed_guard_chk #(
    parameter int unsigned OFF_TICKS = 900
) (
    input logic clk,
    input logic rst_n,
    input logic en_i,
    input logic uvlo_i,
    input logic static_i,
    input logic ovld_i,
    input logic tick_i,
    input logic out_en_o,
    input logic ovl_flag_o
);
    localparam int unsigned RC_W = $clog2(OFF_TICKS + 2);

    logic [RC_W-1:0] rest_cnt;

    // Ticks seen while the output is held off by a fault (rest window).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rest_cnt <= '0;
        end else if (out_en_o || !ovl_flag_o) begin
            rest_cnt <= '0;
        end else if (tick_i && (rest_cnt != {RC_W{1'b1}})) begin
            rest_cnt <= rest_cnt + 1'b1;
        end
    end

    // R1: overload in normal hiccup operation opens a rest window
    a_r1_enter_rest: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !uvlo_i && !static_i && ovld_i && out_en_o && !ovl_flag_o)
        |=> (!out_en_o && ovl_flag_o));

    // R2: the output comes back only after the full rest window
    a_r2_rest_length: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(out_en_o) && $past(en_i && !uvlo_i && !static_i && ovl_flag_o))
        |-> (rest_cnt == RC_W'(OFF_TICKS)));

    // R5: in hiccup mode the flag clears only from an enabled trial window
    a_r5_clear_from_trial: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ovl_flag_o) && $past(en_i && !uvlo_i && !static_i))
        |-> $past(out_en_o));

    // R6: clamp mode keeps the output on and mirrors the overload
    a_r6_clamp_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !uvlo_i && static_i)
        |=> (out_en_o && (ovl_flag_o == $past(ovld_i))));

    // R8: standby or undervoltage forces both outputs low
    a_r8_inactive_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i || uvlo_i) |=> (!out_en_o && !ovl_flag_o));

endmodule

bind olp_pulsed_guard olp_pulsed_guard_chk #(
    .OFF_TICKS (OFF_TICKS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .uvlo_i     (uvlo_i),
    .static_i   (static_i),
    .ovld_i     (ovld_i),
    .tick_i     (tick_i),
    .out_en_o   (out_en_o),
    .ovl_flag_o (ovl_flag_o)
);

// File: tb/olp_pulsed_guard_tb.sv
module olp_pulsed_guard_tb;
    localparam int unsigned OFF_T  = 30;
    localparam int unsigned DIV    = 10;
    localparam int unsigned ON_T   = OFF_T / DIV;
    localparam int unsigned PERIOD = OFF_T + ON_T;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_i = 1'b0, uvlo_i = 1'b0, static_i = 1'b0, ovld_i = 1'b0, tick_i = 1'b0;
    logic out_en_o, ovl_flag_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    olp_pulsed_guard #(.OFF_TICKS(OFF_T), .ON_DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .uvlo_i(uvlo_i),
        .static_i(static_i), .ovld_i(ovld_i), .tick_i(tick_i),
        .out_en_o(out_en_o), .ovl_flag_o(ovl_flag_o)
    );

    // {req[3:0], en, uvlo, static, ovld, exp_out, exp_flag}
    localparam logic [9:0] VEC [15] = '{
        {4'd6, 4'b1010, 2'b10},  // R6 clamp, no overload
        {4'd6, 4'b1011, 2'b11},  // R6 clamp, overload mirrored
        {4'd6, 4'b1011, 2'b11},  // R6
        {4'd6, 4'b1010, 2'b10},  // R6 clamp released
        {4'd8, 4'b0011, 2'b00},  // R8 standby
        {4'd8, 4'b1111, 2'b00},  // R8 undervoltage
        {4'd1, 4'b1000, 2'b10},  // R1 hiccup idle
        {4'd1, 4'b1001, 2'b01},  // R1 overload opens rest
        {4'd2, 4'b1000, 2'b01},  // R2 no tick keeps it off
        {4'd7, 4'b1010, 2'b10},  // R7 switch to clamp mid-rest
        {4'd1, 4'b1001, 2'b01},  // R1 rest again
        {4'd8, 4'b0000, 2'b00},  // R8 standby drops fault
        {4'd8, 4'b1000, 2'b10},  // R8 re-enable is clean
        {4'd1, 4'b1001, 2'b01},  // R1
        {4'd7, 4'b1011, 2'b11}   // R7 clamp during overload
    };

    task automatic drive(input logic en, input logic uv, input logic st,
                         input logic ov, input logic tk);
        @(negedge clk);
        en_i = en; uvlo_i = uv; static_i = st; ovld_i = ov; tick_i = tk;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic eo, input logic ef);
        total++;
        if (out_en_o !== eo || ovl_flag_o !== ef) begin
            bad++;
            $display("FAIL %s: out_en/flag actual=%b%b expected=%b%b at %0t",
                     req, out_en_o, ovl_flag_o, eo, ef, $time);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R9: outputs low in reset even with clamp mode requested
        drive(1, 0, 1, 1, 0);
        check("R9", 1'b0, 1'b0);
        drive(1, 0, 1, 0, 1);
        check("R9", 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 15; i++) begin
            drive(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2], 1'b0);
            check($sformatf("R%0d row %0d", VEC[i][9:6], i), VEC[i][1], VEC[i][0]);
        end

        // R2 R3 R4: overload held, ticks every cycle, repeated hiccup
        drive(0, 0, 0, 0, 0);
        drive(1, 0, 0, 0, 0);
        check("R8", 1'b1, 1'b0);
        for (int k = 0; k < 2 * PERIOD; k++) begin
            drive(1, 0, 0, 1, 1);
            if ((k % PERIOD) < OFF_T) check((k == 0) ? "R1" : "R2", 1'b0, 1'b1);
            else                      check("R3", 1'b1, 1'b1);
        end

        // R5: overload only at entry, clean trial releases the fault
        drive(0, 0, 0, 0, 0);
        drive(1, 0, 0, 0, 0);
        for (int k = 0; k <= PERIOD; k++) begin
            drive(1, 0, 0, (k == 0), 1);
            if (k < OFF_T)       check("R2", 1'b0, 1'b1);
            else if (k < PERIOD) check("R3", 1'b1, 1'b1);
            else                 check("R5", 1'b1, 1'b0);
        end

        // R4: overload only on the edge that closes the trial window
        drive(1, 0, 0, 0, 0);
        for (int k = 0; k <= 2 * PERIOD; k++) begin
            drive(1, 0, 0, (k == 0) || (k == PERIOD), 1);
            if (k < OFF_T)                  check("R2", 1'b0, 1'b1);
            else if (k < PERIOD)            check("R3", 1'b1, 1'b1);
            else if (k < PERIOD + OFF_T)    check("R4", 1'b0, 1'b1);
            else if (k < 2 * PERIOD)        check("R3", 1'b1, 1'b1);
            else                            check("R5", 1'b1, 1'b0);
        end

        // R8: undervoltage in the rest window clears the fault
        drive(1, 0, 0, 1, 1);
        check("R1", 1'b0, 1'b1);
        drive(1, 1, 0, 1, 1);
        check("R8", 1'b0, 1'b0);
        drive(1, 0, 0, 0, 1);
        check("R8", 1'b1, 1'b0);

        // R7: clamp request during the trial window
        drive(1, 0, 0, 1, 1);
        for (int k = 1; k < OFF_T + 1; k++) drive(1, 0, 0, 1, 1);
        check("R3", 1'b1, 1'b1);
        drive(1, 0, 1, 0, 1);
        check("R7", 1'b1, 1'b0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule